// File: doc/BRIEF.md
# LIN DMA Frame Byte Sequencer

This block sits between a byte-wide DMA channel and the byte path of a LIN frame engine. Its request strobes pace the DMA: a transmit-ready level asks for the next byte of the write stream, and a one-clock receive-ready pulse hands a byte over to the read stream. Every transfer on either side is exactly one byte.

The frame configuration comes from one of two sources. When the in-band input is high, the write stream opens with a control byte and a data-length byte, and the identifier follows. When it is low, the configuration is taken from register-style inputs and the write stream opens directly with the identifier. The node action in the configuration then steers the response. Publish pulls the response bytes from the write stream. Subscribe delivers received bytes to the read stream. Ignore moves no response bytes at all. The identifier reaches the engine with its two parity bits filled in, unless parity is disabled.

Top module: `lin_dma_seq`

## Requirements
- R1: After reset, tx_ready is 1, rx_ready is 0 and eng_tx_valid is 0.
- R2: With cfg_inband=1, the first accepted write byte is the control byte and the second is the data-length code. The control byte layout is [1:0] node action (00 publish, 01 subscribe, 10 ignore), [2] parity disable, [3] checksum disable, [4] checksum type, [5] length mode, [6] slot disable. The control byte appears on eng_ctrl from the identifier's acceptance onward.
- R3: With cfg_inband=0, the first accepted write byte is the identifier. eng_ctrl and the length are then taken from reg_ctrl and reg_dlc as sampled at that acceptance.
- R4: The identifier goes to the engine with eng_tx_id=1 and carries parity bits. Bit 6 is id0^id1^id2^id4 and bit 7 is NOT(id1^id3^id4^id5), over the low 6 bits. When parity disable is set, the byte passes unchanged.
- R5: eng_len gives the response length. With length mode 1 it is the data-length code plus one, saturated at 8. With length mode 0 it comes from identifier bits [5:4]: 00 and 01 give 2, 10 gives 4, and 11 gives 8.
- R6: On publish, exactly eng_len further write bytes go to the engine unchanged and in order, with eng_tx_id=0. After that, tx_ready stays 0 until the frame completes.
- R7: On subscribe, each eng_rx_valid cycle of the response gives one rx_ready pulse one clock later, carrying that byte on rx_data. Bytes beyond eng_len produce no pulse.
- R8: On ignore, no response bytes are taken from the write stream and no rx_ready pulse occurs. tx_ready stays 0 until the frame completes.
- R9: While a byte waits for eng_tx_ack, tx_ready is 0 and eng_tx_valid and eng_tx_data hold steady.
- R10: eng_frame_done after the response returns the block to the header stage, and tx_ready rises again.
- R11: eng_rx_valid outside a subscribe response produces no rx_ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inband | input | 1 | 1: configuration arrives in the write stream |
| reg_ctrl | input | 8 | Control byte used when cfg_inband is 0 |
| reg_dlc | input | 8 | Data-length code used when cfg_inband is 0 |
| dma_wr_valid | input | 1 | DMA offers a write byte |
| dma_wr_data | input | 8 | Write byte |
| tx_ready | output | 1 | Write request; a byte is taken when it and dma_wr_valid are both high |
| rx_ready | output | 1 | One-clock read request per received byte |
| rx_data | output | 8 | Received byte |
| eng_ctrl | output | 8 | Active control byte |
| eng_len | output | LEN_W | Active response length |
| eng_tx_valid | output | 1 | Byte pending toward the engine |
| eng_tx_data | output | 8 | Pending byte |
| eng_tx_id | output | 1 | Pending byte is the protected identifier |
| eng_tx_ack | input | 1 | Engine takes the pending byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte from the engine |
| eng_frame_done | input | 1 | Frame complete |

## Verification
Two situations are the hardest to reach from the ports. The first is a byte held at the engine boundary while the DMA keeps offering data. The bench engine model holds back its acknowledge for several cycles during a full-length publish, and it checks that the request stays low each cycle. The second is a received byte that arrives outside a subscribe response. Such bytes are injected before any header, during an ignore frame, and past the end of a subscribe response, and a scoreboard that never expects them flags any resulting pulse.

// File: rtl/lin_dma_pkg.sv
package lin_dma_pkg;
   typedef enum logic [1:0] {
      NACT_PUB = 2'b00,
      NACT_SUB = 2'b01,
      NACT_IGN = 2'b10
   } nact_e;

   typedef enum logic [2:0] {
      ST_HEAD,
      ST_DLC,
      ST_ID,
      ST_TXD,
      ST_RXD,
      ST_WAIT
   } seq_st_e;

   localparam int CTRL_PARDIS_BIT = 2;
   localparam int CTRL_LENMODE_BIT = 5;
   localparam int ID_BITS = 6;
endpackage

// File: rtl/lin_dma_pid.sv
module lin_dma_pid #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] id_in,
   input  logic              par_dis,
   output logic [DATA_W-1:0] pid_out
);
   import lin_dma_pkg::*;
   localparam int NPAR = DATA_W - ID_BITS;
   // per parity bit: 6-bit tap mask and inversion flag
   localparam logic [2*ID_BITS-1:0] TAPS = {6'b111010, 6'b010111};
   localparam logic [1:0] INVERT = 2'b10;

   initial begin
      assert (NPAR == 2) else $error("lin_dma_pid: DATA_W must leave two parity bits");
   end

   logic [1:0] par;
   for (genvar g = 0; g < 2; g++) begin : g_par
      assign par[g] = (^(id_in[ID_BITS-1:0] & TAPS[g*ID_BITS +: ID_BITS])) ^ INVERT[g];
   end

   assign pid_out = par_dis ? id_in : {par, id_in[ID_BITS-1:0]};
endmodule

// File: rtl/lin_dma_len.sv
module lin_dma_len #(
   parameter int DATA_W = 8,
   parameter int MAX_LEN = 8,
   localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
   input  logic              len_mode,
   input  logic [DATA_W-1:0] dlc,
   input  logic [DATA_W-1:0] id_in,
   output logic [LEN_W-1:0]  len
);
   initial begin
      assert (MAX_LEN >= 8 && MAX_LEN < (1 << DATA_W))
         else $error("lin_dma_len: MAX_LEN out of range");
   end

   always_comb begin
      if (len_mode) begin
         if (dlc >= DATA_W'(MAX_LEN - 1)) len = LEN_W'(MAX_LEN);
         else                             len = LEN_W'(dlc) + LEN_W'(1);
      end else begin
         case (id_in[5:4])
            2'b10:   len = LEN_W'(4);
            2'b11:   len = LEN_W'(8);
            default: len = LEN_W'(2);
         endcase
      end
   end
endmodule

// File: rtl/lin_dma_txbuf.sv
module lin_dma_txbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_id,
   input  logic              ack,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              is_id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         is_id <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
         is_id <= load_id;
      end else if (ack) begin
         valid <= 1'b0;
      end
   end

   assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ack |=> valid && $stable(data) && $stable(is_id));
   assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid);
endmodule

// File: rtl/lin_dma_seq.sv
module lin_dma_seq #(
   parameter int DATA_W = 8,
   parameter int MAX_LEN = 8,
   localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_inband,
   input  logic [DATA_W-1:0] reg_ctrl,
   input  logic [DATA_W-1:0] reg_dlc,
   input  logic              dma_wr_valid,
   input  logic [DATA_W-1:0] dma_wr_data,
   output logic              tx_ready,
   output logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] eng_ctrl,
   output logic [LEN_W-1:0]  eng_len,
   output logic              eng_tx_valid,
   output logic [DATA_W-1:0] eng_tx_data,
   output logic              eng_tx_id,
   input  logic              eng_tx_ack,
   input  logic              eng_rx_valid,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              eng_frame_done
);
   import lin_dma_pkg::*;

   initial begin
      assert (DATA_W == 8) else $error("lin_dma_seq: byte-wide transfers only");
   end

   seq_st_e           state;
   logic [LEN_W-1:0]  cnt;
   logic [DATA_W-1:0] hdr_ctrl_q, hdr_dlc_q, act_ctrl_q;
   logic [LEN_W-1:0]  act_len_q;
   logic              rx_ready_q;
   logic [DATA_W-1:0] rx_data_q;

   logic [DATA_W-1:0] eff_ctrl, eff_dlc, pid;
   logic [LEN_W-1:0]  len_now, cnt_inc;
   logic              id_slot, want_wr, wr_fire, rx_fire, buf_load;
   nact_e             nact_now;

   assign eff_ctrl = cfg_inband ? hdr_ctrl_q : reg_ctrl;
   assign eff_dlc  = cfg_inband ? hdr_dlc_q  : reg_dlc;
   assign nact_now = nact_e'(eff_ctrl[1:0]);
   assign id_slot  = (state == ST_ID) || (state == ST_HEAD && !cfg_inband);
   assign want_wr  = (state == ST_HEAD) || (state == ST_DLC) || (state == ST_ID) ||
                     (state == ST_TXD);
   assign tx_ready = want_wr && !eng_tx_valid;
   assign wr_fire  = tx_ready && dma_wr_valid;
   assign rx_fire  = (state == ST_RXD) && eng_rx_valid;
   assign buf_load = wr_fire && (id_slot || state == ST_TXD);
   assign cnt_inc  = cnt + LEN_W'(1);

   lin_dma_pid #(.DATA_W(DATA_W)) u_pid (
      .id_in   (dma_wr_data),
      .par_dis (eff_ctrl[CTRL_PARDIS_BIT]),
      .pid_out (pid)
   );

   lin_dma_len #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_len (
      .len_mode (eff_ctrl[CTRL_LENMODE_BIT]),
      .dlc      (eff_dlc),
      .id_in    (dma_wr_data),
      .len      (len_now)
   );

   lin_dma_txbuf #(.DATA_W(DATA_W)) u_txbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (buf_load),
      .load_data (id_slot ? pid : dma_wr_data),
      .load_id   (id_slot),
      .ack       (eng_tx_ack),
      .valid     (eng_tx_valid),
      .data      (eng_tx_data),
      .is_id     (eng_tx_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_HEAD;
         cnt        <= '0;
         hdr_ctrl_q <= '0;
         hdr_dlc_q  <= '0;
         act_ctrl_q <= '0;
         act_len_q  <= LEN_W'(1);
      end else begin
         case (state)
            ST_HEAD, ST_ID: begin
               if (wr_fire && !id_slot) begin
                  hdr_ctrl_q <= dma_wr_data;
                  state      <= ST_DLC;
               end else if (wr_fire) begin
                  act_ctrl_q <= eff_ctrl;
                  act_len_q  <= len_now;
                  cnt        <= '0;
                  case (nact_now)
                     NACT_PUB: state <= ST_TXD;
                     NACT_SUB: state <= ST_RXD;
                     default:  state <= ST_WAIT;
                  endcase
               end
            end
            ST_DLC: begin
               if (wr_fire) begin
                  hdr_dlc_q <= dma_wr_data;
                  state     <= ST_ID;
               end
            end
            ST_TXD: begin
               if (wr_fire) begin
                  cnt <= cnt_inc;
                  if (cnt_inc == act_len_q) state <= ST_WAIT;
               end
            end
            ST_RXD: begin
               if (rx_fire) begin
                  cnt <= cnt_inc;
                  if (cnt_inc == act_len_q) state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (eng_frame_done) state <= ST_HEAD;
            end
            default: state <= ST_HEAD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ready_q <= 1'b0;
         rx_data_q  <= '0;
      end else begin
         rx_ready_q <= rx_fire;
         if (rx_fire) rx_data_q <= eng_rx_data;
      end
   end

   assign rx_ready = rx_ready_q;
   assign rx_data  = rx_data_q;
   assign eng_ctrl = act_ctrl_q;
   assign eng_len  = act_len_q;

   assert_rx_follows_engine_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> $past(eng_rx_valid));
   assert_rx_only_subscribe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> act_ctrl_q[1:0] == NACT_SUB);
   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TXD || state == ST_RXD) |-> cnt < act_len_q);
   assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_len_q >= LEN_W'(1) && act_len_q <= LEN_W'(MAX_LEN));
   assert_wait_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WAIT && !eng_frame_done |=> state == ST_WAIT);
endmodule

// File: tb/lin_dma_seq_bench.sv
module lin_dma_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_inband = 1'b1;
   logic [7:0] reg_ctrl = 8'h00, reg_dlc = 8'h00;
   logic       dma_wr_valid = 1'b0;
   logic [7:0] dma_wr_data = 8'h00;
   logic       tx_ready, rx_ready, eng_tx_valid, eng_tx_id;
   logic [7:0] rx_data, eng_ctrl, eng_tx_data;
   logic [3:0] eng_len;
   logic       eng_tx_ack = 1'b0, eng_rx_valid = 1'b0, eng_frame_done = 1'b0;
   logic [7:0] eng_rx_data = 8'h00;

   int checks = 0, failures = 0, ack_delay = 0, wait_cnt = 0;
   logic [8:0] exp_tx[$];
   logic [7:0] exp_rx[$];

   always #10 clk = ~clk;

   lin_dma_seq u_lin_dma_seq (
      .clk(clk), .rst_n(rst_n), .cfg_inband(cfg_inband), .reg_ctrl(reg_ctrl),
      .reg_dlc(reg_dlc), .dma_wr_valid(dma_wr_valid), .dma_wr_data(dma_wr_data),
      .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_data(rx_data),
      .eng_ctrl(eng_ctrl), .eng_len(eng_len), .eng_tx_valid(eng_tx_valid),
      .eng_tx_data(eng_tx_data), .eng_tx_id(eng_tx_id), .eng_tx_ack(eng_tx_ack),
      .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
      .eng_frame_done(eng_frame_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pid_of(input logic [7:0] id, input bit pardis);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return pardis ? id : {p1, p0, id[5:0]};
   endfunction

   // engine model: pops expected transmit bytes, acknowledges after ack_delay cycles
   initial begin
      forever begin
         @(negedge clk);
         eng_tx_ack = 1'b0;
         if (eng_tx_valid) begin
            check(tx_ready == 1'b0, "R9 tx_ready while pending", tx_ready, 0);
            if (wait_cnt < ack_delay) wait_cnt++;
            else begin
               wait_cnt = 0;
               if (exp_tx.size() == 0)
                  check(1'b0, "R8 unexpected engine byte", {eng_tx_id, eng_tx_data}, 0);
               else begin
                  logic [8:0] e;
                  e = exp_tx.pop_front();
                  check({eng_tx_id, eng_tx_data} == e, e[8] ? "R4 identifier" : "R6 data",
                        {eng_tx_id, eng_tx_data}, e);
               end
               eng_tx_ack = 1'b1;
            end
         end
      end
   end

   // read-stream monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rx_ready) begin
            if (exp_rx.size() == 0) check(1'b0, "R11 unexpected rx_ready", rx_data, 0);
            else begin
               logic [7:0] e;
               e = exp_rx.pop_front();
               check(rx_data == e, "R7 rx byte", rx_data, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic wr_byte(input logic [7:0] b);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      dma_wr_valid = 1'b1;
      dma_wr_data  = b;
      @(negedge clk);
      dma_wr_valid = 1'b0;
   endtask

   task automatic wr_id(input logic [7:0] id, input bit pardis);
      exp_tx.push_back({1'b1, pid_of(id, pardis)});
      wr_byte(id);
   endtask

   task automatic wr_data(input logic [7:0] b);
      exp_tx.push_back({1'b0, b});
      wr_byte(b);
   endtask

   task automatic rx_byte(input logic [7:0] b, input bit expect_it);
      @(negedge clk);
      eng_rx_valid = 1'b1;
      eng_rx_data  = b;
      if (expect_it) exp_rx.push_back(b);
      @(negedge clk);
      eng_rx_valid = 1'b0;
   endtask

   task automatic finish_frame(input string req);
      while (exp_tx.size() != 0 || eng_tx_valid || exp_rx.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(tx_ready == 1'b0, req, tx_ready, 0);
      eng_frame_done = 1'b1;
      @(negedge clk);
      eng_frame_done = 1'b0;
      check(tx_ready == 1'b1, "R10 header stage after done", tx_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
      check(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
      check(eng_tx_valid == 1'b0, "R1 eng_tx_valid", eng_tx_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_ready == 1'b1 && !rx_ready, "R1 after release", tx_ready, 1);

      // R11: received byte before any header
      rx_byte(8'hAA, 1'b0);

      // R2 R5 R6: in-band publish, length from identifier bits (10 -> 4)
      wr_byte(8'h58);   // publish, checksum bits and slot bit set
      wr_byte(8'h07);
      wr_id(8'h25, 1'b0);
      check(eng_ctrl == 8'h58, "R2 eng_ctrl", eng_ctrl, 8'h58);
      check(eng_len == 4'd4, "R5 classic length 4", eng_len, 4);
      for (int i = 0; i < 4; i++) wr_data(8'h10 + 8'(i));
      finish_frame("R6 tx_ready low after response");

      // R4 R5 R7: in-band subscribe, parity off, length mode dlc=2 -> 3
      wr_byte(8'h25);
      wr_byte(8'h02);
      wr_id(8'hC7, 1'b1);
      check(eng_len == 4'd3, "R5 dlc+1", eng_len, 3);
      rx_byte(8'h31, 1'b1);
      rx_byte(8'h32, 1'b1);
      rx_byte(8'h33, 1'b1);
      rx_byte(8'h34, 1'b0);   // beyond length
      finish_frame("R7 tx_ready low after response");

      // R8: ignore frame
      wr_byte(8'h02);
      wr_byte(8'h00);
      wr_id(8'h3C, 1'b0);
      rx_byte(8'h55, 1'b0);
      rx_byte(8'h66, 1'b0);
      finish_frame("R8 tx_ready low on ignore");

      // R5 R9: saturated length 8 with slow engine acknowledge
      ack_delay = 3;
      wr_byte(8'h20);
      wr_byte(8'd20);
      wr_id(8'h11, 1'b0);
      check(eng_len == 4'd8, "R5 saturated length", eng_len, 8);
      for (int i = 0; i < 8; i++) wr_data(8'hA0 + 8'(i));
      finish_frame("R6 tx_ready low after 8 bytes");
      ack_delay = 0;

      // R3: register-sourced configuration, subscribe, id[5:4]=00 -> 2
      @(negedge clk);
      cfg_inband = 1'b0;
      reg_ctrl   = 8'h01;
      reg_dlc    = 8'h05;
      wr_id(8'h0A, 1'b0);
      reg_ctrl = 8'h02;   // change after sampling must not matter
      check(eng_ctrl == 8'h01, "R3 eng_ctrl from register", eng_ctrl, 1);
      check(eng_len == 4'd2, "R3 length from register mode", eng_len, 2);
      rx_byte(8'hC1, 1'b1);
      rx_byte(8'hC2, 1'b1);
      finish_frame("R7 tx_ready low in register mode");

      // R3: register-sourced publish, id[5:4]=01 -> 2
      reg_ctrl = 8'h00;
      wr_id(8'h1B, 1'b0);
      check(eng_len == 4'd2, "R3 publish length", eng_len, 2);
      wr_data(8'hE1);
      wr_data(8'hE2);
      finish_frame("R6 tx_ready low in register mode");

      repeat (4) @(negedge clk);
      check(exp_tx.size() == 0, "R6 engine queue drained", exp_tx.size(), 0);
      check(exp_rx.size() == 0, "R7 read queue drained", exp_rx.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule